// File: doc/BRIEF.md
# Pixel Conversion Mode Controller

This block decides whether pixel words written by a host processor reach the graphics memory untouched or pass through a colour-space converter first. Software writes a 16-bit control word. Its two lowest bits pick one of three modes: pass-through, luma/chroma-to-RGB, or delta-coded luma/chroma-to-RGB. When a converting mode is written, the block takes the pixel budget for the job from two image-size inputs, width times height, and loads it into a countdown.

The converter pulses a strobe for every pixel it finishes. Each pulse lowers the remaining count by one. When the last pixel is done, the block drops back to pass-through without help from software. While a conversion is running, the block withdraws the host's direct access grant to the graphics memory. The mode and the remaining count are kept through a reset, so a job that a reset interrupts carries on when the reset ends.

Top module: `cvm_ctrl`

## Requirements
- R1: The control word is 16 bits. Bits [1:0] hold the mode. A read returns the mode in bits [1:0] and 0 in bits [15:2], whatever was written to those bits.
- R2: Mode codes are 00 pass-through, 01 luma/chroma conversion and 10 delta luma/chroma conversion. A write whose bits [1:0] are 11 has no effect: the mode and the count stay as they were, and a strobe in that cycle is handled as if no write occurred.
- R3: A write of 01 or 10 loads the remaining count with size_x times size_y on the same clock edge that updates the mode.
- R4: While the mode is 01 or 10, each pix_done pulse lowers the remaining count by exactly one. In mode 00 a pulse leaves the count unchanged.
- R5: The pulse that takes the count from 1 to 0 sets the mode to 00 on that same edge. After that edge, busy is low and mem_grant is high.
- R6: busy is high and mem_grant is low exactly when the mode is 01 or 10. In mode 00, busy is low and mem_grant is high.
- R7: While rst_n is low, the mode and the remaining count keep their values, and writes and pix_done pulses are ignored.
- R8: If a converting mode is written while the size product is 0, the mode reads as the written code for one cycle and then returns to 00, with no pixel processed.
- R9: A legal write overrides a pix_done pulse in the same cycle. A write of 00 ends a conversion at once and leaves the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. While low, all updates are frozen. |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| size_x | input | XW | Image width in pixels |
| size_y | input | YW | Image height in pixels |
| pix_done | input | 1 | One pulse for each pixel the converter finishes |
| mode_out | output | 2 | Current mode code |
| busy | output | 1 | High while a conversion is running |
| mem_grant | output | 1 | Host direct access to graphics memory is allowed |
| pix_remaining | output | XW+YW | Pixels left in the current job |

## Verification
The bench builds the block with XW = YW = 4, so the count is 8 bits wide. That small width brings within reach both the largest job, 15 × 15 = 225 pixels, and zero-sized jobs. It lets random runs finish whole conversions many times over. Random sizes, writes (including the ignored code 11 and nonzero reserved bits), strobes and short reset pulses are mixed with directed cases: the last-pixel clear, the empty job, an abort that coincides with a strobe, and a reset in the middle of a job.

// File: rtl/cvm_pkg.sv
package cvm_pkg;

  typedef enum logic [1:0] {
    CVM_PASS = 2'b00,
    CVM_YUV  = 2'b01,
    CVM_DYUV = 2'b10,
    CVM_BAD  = 2'b11
  } cvm_mode_e;

  localparam int unsigned CVM_REG_W  = 16;
  localparam int unsigned CVM_MODE_W = 2;

  // True for a mode code that runs the converter
  function automatic logic is_conv(input logic [1:0] m);
    return (m == CVM_YUV) || (m == CVM_DYUV);
  endfunction

  // True for a mode code that a write may take
  function automatic logic is_taken(input logic [1:0] m);
    return m != CVM_BAD;
  endfunction

endpackage

// File: rtl/cvm_wr_decode.sv
module cvm_wr_decode
  import cvm_pkg::*;
#(
  parameter int unsigned REG_W = CVM_REG_W
) (
  input  logic             run,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic             wr_conv,
  output logic             wr_pass,
  output logic             wr_bad,
  output logic [1:0]       wr_mode
);

  logic wr_live;
  logic unused_rsvd;

  assign wr_live = run && reg_wr;
  assign wr_mode = reg_wdata[CVM_MODE_W-1:0];
  assign wr_conv = wr_live && is_conv(wr_mode);
  assign wr_pass = wr_live && (wr_mode == CVM_PASS);
  assign wr_bad  = wr_live && !is_taken(wr_mode);

  // reserved bits take part in nothing
  assign unused_rsvd = ^reg_wdata[REG_W-1:CVM_MODE_W];

  always_comb begin
    a_r2_decode_exclusive: assert ($onehot0({wr_conv, wr_pass, wr_bad}));
  end

endmodule

// File: rtl/cvm_countdown.sv
module cvm_countdown #(
  parameter int unsigned CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          dec,
  output logic [CW-1:0] cnt_q,
  output logic          last_pix,
  output logic          cnt_zero
);

  localparam logic [CW-1:0] ONE = CW'(1);

  // no reset term: the count is kept through a reset on purpose
  always_ff @(posedge clk) begin
    if (ld) begin
      cnt_q <= ld_val;
    end else if (dec && !cnt_zero) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign last_pix = dec && (cnt_q == ONE);

  a_r3_load_takes_product: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt_q == $past(ld_val)));

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !ld && !cnt_zero) |=> (cnt_q == $past(cnt_q) - ONE));

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !ld) |=> $stable(cnt_q));

endmodule

// File: rtl/cvm_mode_reg.sv
module cvm_mode_reg
  import cvm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_conv,
  input  logic       ld_pass,
  input  logic [1:0] wr_mode,
  input  logic       auto_clr,
  output logic [1:0] mode_q
);

  // no reset term: the mode survives a reset
  always_ff @(posedge clk) begin
    if (ld_conv) begin
      mode_q <= wr_mode;
    end else if (ld_pass || auto_clr) begin
      mode_q <= CVM_PASS;
    end
  end

  a_r9_pass_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pass |=> (mode_q == CVM_PASS));

  a_r2_conv_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ld_conv |=> is_conv(mode_q));

endmodule

// File: rtl/cvm_ctrl.sv
module cvm_ctrl
  import cvm_pkg::*;
#(
  parameter int unsigned XW = 10,
  parameter int unsigned YW = 10,
  localparam int unsigned CW = XW + YW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [CVM_REG_W-1:0] reg_wdata,
  output logic [CVM_REG_W-1:0] reg_rdata,
  input  logic [XW-1:0]        size_x,
  input  logic [YW-1:0]        size_y,
  input  logic                 pix_done,
  output logic [1:0]           mode_out,
  output logic                 busy,
  output logic                 mem_grant,
  output logic [CW-1:0]        pix_remaining
);

  function automatic logic [CW-1:0] pixel_total(input logic [XW-1:0] x,
                                                input logic [YW-1:0] y);
    return CW'(x) * CW'(y);
  endfunction

  // named internal events
  logic          run;
  logic          wr_conv, wr_pass, wr_bad;
  logic          wr_take;
  logic [1:0]    wr_mode;
  logic [1:0]    mode_q;
  logic          conv_on;
  logic          dec;
  logic          last_pix;
  logic          cnt_zero;
  logic          auto_clr;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt_q;

  assign run = rst_n;

  cvm_wr_decode #(.REG_W(CVM_REG_W)) u_dec (
    .run      (run),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .wr_conv  (wr_conv),
    .wr_pass  (wr_pass),
    .wr_bad   (wr_bad),
    .wr_mode  (wr_mode)
  );

  assign wr_take  = wr_conv || wr_pass;
  assign conv_on  = is_conv(mode_q);
  assign dec      = run && conv_on && pix_done && !wr_take;
  assign load_val = pixel_total(size_x, size_y);

  cvm_countdown #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (wr_conv),
    .ld_val  (load_val),
    .dec     (dec),
    .cnt_q   (cnt_q),
    .last_pix(last_pix),
    .cnt_zero(cnt_zero)
  );

  assign auto_clr = run && conv_on && (last_pix || cnt_zero);

  cvm_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_conv (wr_conv),
    .ld_pass (wr_pass),
    .wr_mode (wr_mode),
    .auto_clr(auto_clr),
    .mode_q  (mode_q)
  );

  assign mode_out      = mode_q;
  assign busy          = conv_on;
  assign mem_grant     = !conv_on;
  assign pix_remaining = cnt_q;
  assign reg_rdata     = {{(CVM_REG_W-CVM_MODE_W){1'b0}}, mode_q};

  a_r2_no_bad_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != CVM_BAD);

  a_r2_bad_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && !pix_done && !cnt_zero) |=> ($stable(mode_q) && $stable(cnt_q)));

  a_r5_last_pixel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (last_pix && !wr_take) |=> (mode_q == CVM_PASS && cnt_q == '0));

  a_r6_grant_withheld: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != CVM_PASS) |-> (!mem_grant && busy));

  a_r8_empty_job_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_on && cnt_zero && !wr_take) |=> (mode_q == CVM_PASS));

  a_r9_write_beats_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pass && pix_done) |=> $stable(cnt_q));

endmodule

// File: tb/tb_cvm_ctrl.sv
module tb_cvm_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int XW = 4;
  localparam int YW = 4;
  localparam int CW = XW + YW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [XW-1:0] size_x = '0;
  logic [YW-1:0] size_y = '0;
  logic          pix_done = 1'b0;
  logic [1:0]    mode_out;
  logic          busy, mem_grant;
  logic [CW-1:0] pix_remaining;

  int n_chk = 0;
  int n_bad = 0;
  bit chk_en = 0;
  bit done = 0;
  int m_mode = 0;
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvm_ctrl #(.XW(XW), .YW(YW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .size_x(size_x), .size_y(size_y),
    .pix_done(pix_done), .mode_out(mode_out), .busy(busy),
    .mem_grant(mem_grant), .pix_remaining(pix_remaining)
  );

  function automatic int job_size(input int x, input int y);
    return x * y;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R2 mode"}, int'(mode_out), m_mode);
    chk({ctx, " R4 remaining"}, int'(pix_remaining), m_cnt);
    chk({ctx, " R6 busy"}, int'(busy), (m_mode != 0) ? 1 : 0);
    chk({ctx, " R6 grant"}, int'(mem_grant), (m_mode == 0) ? 1 : 0);
    chk({ctx, " R1 rdata"}, int'(reg_rdata), m_mode);
  endtask

  // update the reference model for one clock edge
  task automatic model_edge(input bit wr, input logic [15:0] wd, input bit pix, input bit rs);
    int code;
    code = int'(wd[1:0]);
    if (!rs) return;
    if (wr && (code == 1 || code == 2)) begin
      m_mode = code;
      m_cnt = job_size(int'(size_x), int'(size_y));
    end else if (wr && code == 0) begin
      m_mode = 0;
    end else if (m_mode != 0) begin
      if (m_cnt == 0) m_mode = 0;
      else if (pix) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_mode = 0;
      end
    end
  endtask

  task automatic step(input string ctx, input bit wr, input logic [15:0] wd,
                      input bit pix, input bit rs);
    reg_wr = wr; reg_wdata = wd; pix_done = pix; rst_n = rs;
    @(posedge clk);
    model_edge(wr, wd, pix, rs);
    @(negedge clk);
    reg_wr = 1'b0; pix_done = 1'b0;
    if (chk_en) check_all(ctx);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("init", 0, 16'h0, 0, 0);
    step("init", 0, 16'h0, 0, 0);
    // settle unknown power-up state with an empty job
    size_x = 0; size_y = 0;
    step("init", 1, 16'h0001, 0, 1);
    step("init", 0, 16'h0, 0, 1);
    m_mode = 0; m_cnt = 0;
    chk_en = 1;
    check_all("reset state");

    // R1 reserved bits set on write, R3 load of 3x5
    size_x = 3; size_y = 5;
    step("R1 R3 load", 1, 16'hFFFE, 0, 1);
    chk("R3 count loaded", int'(pix_remaining), 15);
    chk("R1 reserved read zero", int'(reg_rdata), 2);
    for (int i = 0; i < 3; i++) step("R4 strobe", 0, 16'h0, 1, 1);
    chk("R4 after three strobes", int'(pix_remaining), 12);

    // R7 reset mid-job with writes and strobes driven
    step("R7 in reset", 1, 16'h0000, 1, 0);
    step("R7 in reset", 0, 16'h0, 1, 0);
    step("R7 in reset", 1, 16'h0001, 1, 0);
    step("R7 after reset", 0, 16'h0, 0, 1);
    chk("R7 mode kept", int'(mode_out), 2);
    chk("R7 count kept", int'(pix_remaining), 12);

    // R2 write of 11 ignored
    step("R2 bad code", 1, 16'h0003, 0, 1);
    chk("R2 bad code mode", int'(mode_out), 2);
    step("R2 bad code with strobe", 1, 16'h0003, 1, 1);
    chk("R2 bad code strobe counts", int'(pix_remaining), 11);

    // R9 abort with coincident strobe
    step("R9 abort", 1, 16'h0000, 1, 1);
    chk("R9 abort mode", int'(mode_out), 0);
    chk("R9 abort count kept", int'(pix_remaining), 11);
    step("R4 strobe in pass", 0, 16'h0, 1, 1);
    chk("R4 pass strobe no change", int'(pix_remaining), 11);

    // R5 two-pixel job
    size_x = 1; size_y = 2;
    step("R5 load", 1, 16'h0001, 0, 1);
    step("R5 first", 0, 16'h0, 1, 1);
    chk("R5 still busy", int'(busy), 1);
    step("R5 last", 0, 16'h0, 1, 1);
    chk("R5 mode cleared", int'(mode_out), 0);
    chk("R5 grant back", int'(mem_grant), 1);

    // R8 empty job
    size_x = 0; size_y = 9;
    step("R8 load empty", 1, 16'h0002, 1, 1);
    chk("R8 one cycle busy", int'(mode_out), 2);
    step("R8 clears", 0, 16'h0, 0, 1);
    chk("R8 cleared", int'(mode_out), 0);

    // largest job
    size_x = 15; size_y = 15;
    step("R3 max load", 1, 16'h0001, 0, 1);
    chk("R3 max count", int'(pix_remaining), 225);
    for (int i = 0; i < 225; i++) step("R4 max run", 0, 16'h0, 1, 1);
    chk("R5 max job done", int'(mode_out), 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit wr, pix, rs;
      logic [15:0] wd;
      r = int'($urandom_range(0, 99));
      wr = (r < 6);
      wd = 16'($urandom);
      pix = ($urandom_range(0, 99) < 55);
      rs = ($urandom_range(0, 99) >= 3);
      if (wr) begin
        size_x = XW'($urandom_range(0, 6));
        size_y = YW'($urandom_range(0, 6));
      end
      step("R4 R9 random", wr, wd, pix, rs);
    end

    done = 1;
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule